// File: doc/BRIEF.md
# Eight-Bit Accumulator ALU with Packed Condition Flags

This block is the arithmetic and logic stage of a small accumulator-oriented datapath. Each cycle it takes the accumulator value, a second operand from a holding register and a 4-bit operation code, and it produces an 8-bit result without any register delay. The result depends on the inputs and on the carry and auxiliary-carry bits held in the block's own flag register.

A flag-write strobe commits the flags for the current operation on the next rising clock edge. The flags are kept as one byte with fixed bit positions. Bit 7 is sign, bit 6 is zero, bit 4 is auxiliary carry (the carry from the low nibble into the high nibble), bit 2 is even parity and bit 0 is carry or borrow. Bits 1, 3 and 5 are fixed constants.

The operations are add and subtract, each with or without the stored carry, and compare. There are also bitwise AND, OR and XOR, one's complement, four one-bit rotates, and a decimal adjust that corrects the accumulator after adding two packed two-digit BCD values.

Top module: `alu8_flags`

## Requirements
- R1: The flag byte is {S, Z, 0, AC, 0, P, 1, CY} from bit 7 down to bit 0. A synchronous active-high reset loads 8'h02. Bit 1 always reads 1, and bits 3 and 5 always read 0.
- R2: Every operation that updates S, Z and P sets them from its flag source value. S is bit 7 of that value, Z is 1 when all 8 bits are zero, and P is 1 when the number of ones is even. For compare, the flag source is the difference. For every other such operation, it is the result.
- R3: Op 0 adds acc_in and opnd_in. Op 1 adds acc_in, opnd_in and the stored CY. The result is the low 8 bits of the sum. CY is the carry out of bit 7, and AC is the carry out of bit 3.
- R4: Op 2 computes acc_in minus opnd_in. Op 3 also subtracts the stored CY as a borrow. CY is 1 when a borrow occurs. AC is the carry out of bit 3 of acc_in + ~opnd_in + (1 - borrow_in).
- R5: Op 4 (compare) sets every flag exactly as op 2 would. The result output equals acc_in.
- R6: Op 5 is AND, op 6 is OR and op 7 is XOR of acc_in and opnd_in. These three clear both CY and AC.
- R7: Op 8 outputs the bitwise inverse of acc_in and leaves every flag unchanged.
- R8: The rotates change only CY. Op 9 rotates left and loads CY from bit 7. Op 10 rotates right and loads CY from bit 0. Op 11 rotates left through CY: the old CY enters bit 0 and the new CY is bit 7. Op 12 rotates right through CY: the old CY enters bit 7 and the new CY is bit 0.
- R9: Op 13 (decimal adjust) adds 0x06 when the low nibble of acc_in is above 9 or AC is set. It adds 0x60 when the high nibble of acc_in is above 9 or CY is set. CY becomes 1 exactly when the 0x60 correction applies. AC is the carry out of bit 3 of that addition.
- R10: The flags change only on a rising edge at which flag_we is 1. When flag_we is 0, the flags hold their value. Every op that consumes a carry uses the flags held before the edge: add with carry, subtract with borrow, the rotates through carry and decimal adjust.
- R11: Codes 14 and 15 are reserved. They output acc_in and leave every flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 4 | Operation code |
| acc_in | input | 8 | Accumulator operand |
| opnd_in | input | 8 | Second operand |
| flag_we | input | 1 | Commit the flags at the next rising edge |
| result | output | 8 | Combinational result |
| flags | output | 8 | Registered flag byte |

## Verification
Carry consumption and carry update can fall in the same cycle. An add with carry, a subtract with borrow, a rotate through carry or a decimal adjust reads the stored CY to form its result, while the same edge writes a new CY. The bench provokes this with back-to-back carry-consuming operations and flag_we held high. The result is judged just before the edge against the old carry, and the flags are judged just after it against the new carry.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  typedef enum logic [3:0] {
    OP_ADD = 4'd0,  OP_ADC = 4'd1,  OP_SUB = 4'd2,  OP_SBB = 4'd3,
    OP_CMP = 4'd4,  OP_AND = 4'd5,  OP_OR  = 4'd6,  OP_XOR = 4'd7,
    OP_NOT = 4'd8,  OP_RLC = 4'd9,  OP_RRC = 4'd10, OP_RAL = 4'd11,
    OP_RAR = 4'd12, OP_DAA = 4'd13, OP_R14 = 4'd14, OP_R15 = 4'd15
  } alu_op_e;

  localparam int F_CY  = 0;
  localparam int F_ONE = 1;
  localparam int F_P   = 2;
  localparam int F_AC  = 4;
  localparam int F_Z   = 6;
  localparam int F_S   = 7;
  localparam logic [7:0] FLAG_RST = 8'h02;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int DW = 8,
  parameter int NW = DW / 2
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          sub,
  input  logic          cin,
  output logic [DW-1:0] sum,
  output logic          cy,
  output logic          ac
);
  logic [DW-1:0] b_eff;
  logic          c0;
  logic [DW:0]   full;

  always_comb begin
    b_eff = sub ? ~b : b;
    c0    = sub ? ~cin : cin;
    full  = {1'b0, a} + {1'b0, b_eff} + {{DW{1'b0}}, c0};
    sum   = full[DW-1:0];
    cy    = sub ? ~full[DW] : full[DW];
    ac    = full[NW] ^ a[NW] ^ b_eff[NW];
  end
endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_op_e       op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cy_in,
  output logic [DW-1:0] res,
  output logic          cy_out
);
  always_comb begin
    res    = a;
    cy_out = cy_in;
    case (op)
      OP_AND: res = a & b;
      OP_OR:  res = a | b;
      OP_XOR: res = a ^ b;
      OP_NOT: res = ~a;
      OP_RLC: begin res = {a[DW-2:0], a[DW-1]}; cy_out = a[DW-1]; end
      OP_RRC: begin res = {a[0], a[DW-1:1]};    cy_out = a[0];    end
      OP_RAL: begin res = {a[DW-2:0], cy_in};   cy_out = a[DW-1]; end
      OP_RAR: begin res = {cy_in, a[DW-1:1]};   cy_out = a[0];    end
      default: ;
    endcase
  end
endmodule

// File: rtl/alu8_decadj.sv
module alu8_decadj #(
  parameter int DW = 8,
  parameter int NW = DW / 2
) (
  input  logic [DW-1:0] a,
  input  logic          ac_in,
  input  logic          cy_in,
  output logic [DW-1:0] res,
  output logic          ac_out,
  output logic          cy_out
);
  localparam logic [NW-1:0] SIX = NW'(6);
  logic          lo_fix, hi_fix;
  logic [DW-1:0] corr;

  always_comb begin
    lo_fix = (a[NW-1:0] > NW'(9)) || ac_in;
    hi_fix = (a[DW-1:NW] > NW'(9)) || cy_in;
    corr   = {hi_fix ? SIX : '0, lo_fix ? SIX : '0};
    res    = a + corr;
    ac_out = res[NW] ^ a[NW] ^ corr[NW];
    cy_out = hi_fix;
  end
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [3:0]    op,
  input  logic [DW-1:0] acc_in,
  input  logic [DW-1:0] opnd_in,
  input  logic          flag_we,
  output logic [DW-1:0] result,
  output logic [7:0]    flags
);
  localparam int NW = DW / 2;

  alu_op_e       op_e;
  logic [7:0]    flags_q, flags_d;
  logic          is_sub, carry_in;
  logic [DW-1:0] as_sum, bo_res, da_res, szp_src;
  logic          as_cy, as_ac, bo_cy, da_cy, da_ac;

  assign op_e     = alu_op_e'(op);
  assign is_sub   = (op_e == OP_SUB) || (op_e == OP_SBB) || (op_e == OP_CMP);
  assign carry_in = ((op_e == OP_ADC) || (op_e == OP_SBB)) && flags_q[F_CY];

  alu8_addsub #(.DW(DW), .NW(NW)) u_addsub (
    .a(acc_in), .b(opnd_in), .sub(is_sub), .cin(carry_in),
    .sum(as_sum), .cy(as_cy), .ac(as_ac)
  );

  alu8_bitops #(.DW(DW)) u_bitops (
    .op(op_e), .a(acc_in), .b(opnd_in), .cy_in(flags_q[F_CY]),
    .res(bo_res), .cy_out(bo_cy)
  );

  alu8_decadj #(.DW(DW), .NW(NW)) u_decadj (
    .a(acc_in), .ac_in(flags_q[F_AC]), .cy_in(flags_q[F_CY]),
    .res(da_res), .ac_out(da_ac), .cy_out(da_cy)
  );

  always_comb begin
    result  = acc_in;
    szp_src = acc_in;
    flags_d = flags_q;
    case (op_e)
      OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_CMP: begin
        result        = (op_e == OP_CMP) ? acc_in : as_sum;
        szp_src       = as_sum;
        flags_d[F_CY] = as_cy;
        flags_d[F_AC] = as_ac;
      end
      OP_AND, OP_OR, OP_XOR: begin
        result        = bo_res;
        szp_src       = bo_res;
        flags_d[F_CY] = 1'b0;
        flags_d[F_AC] = 1'b0;
      end
      OP_NOT: result = bo_res;
      OP_RLC, OP_RRC, OP_RAL, OP_RAR: begin
        result        = bo_res;
        flags_d[F_CY] = bo_cy;
      end
      OP_DAA: begin
        result        = da_res;
        szp_src       = da_res;
        flags_d[F_CY] = da_cy;
        flags_d[F_AC] = da_ac;
      end
      default: ;
    endcase
    case (op_e)
      OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_CMP,
      OP_AND, OP_OR, OP_XOR, OP_DAA: begin
        flags_d[F_S] = szp_src[DW-1];
        flags_d[F_Z] = (szp_src == '0);
        flags_d[F_P] = ~^szp_src;
      end
      default: ;
    endcase
    flags_d[F_ONE] = 1'b1;
    flags_d[3]     = 1'b0;
    flags_d[5]     = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)          flags_q <= FLAG_RST;
    else if (flag_we) flags_q <= flags_d;
  end

  assign flags = flags_q;

  // R1
  reserved_bits_chk: assert property (@(posedge clk) disable iff (rst)
    flags[1] && !flags[3] && !flags[5]);

  // R10
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !flag_we |=> $stable(flags));

  // R6
  logic_clear_chk: assert property (@(posedge clk) disable iff (rst)
    flag_we && (op_e == OP_AND || op_e == OP_OR || op_e == OP_XOR)
    |=> !flags[F_CY] && !flags[F_AC]);

  // R8
  rot_keep_chk: assert property (@(posedge clk) disable iff (rst)
    flag_we && (op_e == OP_RLC || op_e == OP_RRC || op_e == OP_RAL || op_e == OP_RAR)
    |=> flags[7:1] == $past(flags[7:1]));

  // R2
  zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
    flag_we && (op_e == OP_ADD || op_e == OP_SUB || op_e == OP_AND)
    |=> flags[F_Z] == ($past(result) == '0));

  // R7
  not_keep_chk: assert property (@(posedge clk) disable iff (rst)
    flag_we && op_e == OP_NOT |=> $stable(flags));
endmodule

// File: tb/alu8_flags_test.sv
module alu8_flags_test;
  typedef struct {
    logic [7:0] res;
    logic [7:0] fl;
    string      tag;
  } item_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] op = 4'd0;
  logic [7:0] acc_in = 8'h00, opnd_in = 8'h00;
  logic       flag_we = 1'b0;
  logic [7:0] result, flags;

  int    checks = 0, errors = 0;
  item_t q[$];
  logic [7:0] mf = 8'h02;
  bit    done = 1'b0;

  always #2 clk = ~clk;

  alu8_flags uut (
    .clk(clk), .rst(rst), .op(op), .acc_in(acc_in), .opnd_in(opnd_in),
    .flag_we(flag_we), .result(result), .flags(flags)
  );

  function automatic logic [15:0] model(input int o, input logic [7:0] a,
                                        input logic [7:0] b, input logic [7:0] f);
    int cy = f[0], ac = f[4], s, d, add;
    logic [7:0] r = a, src = a, nf = f;
    bit szp = 0, hi;
    case (o)
      0, 1: begin
        s = a + b + ((o == 1) ? cy : 0);
        r = s[7:0]; src = r; szp = 1;
        nf[0] = (s > 255);
        nf[4] = ((a & 15) + (b & 15) + ((o == 1) ? cy : 0)) > 15;
      end
      2, 3, 4: begin
        d = int'(a) - int'(b) - ((o == 3) ? cy : 0);
        src = d[7:0]; r = (o == 4) ? a : src; szp = 1;
        nf[0] = (d < 0);
        nf[4] = ((a & 15) + ((~b) & 15) + 1 - ((o == 3) ? cy : 0)) > 15;
      end
      5, 6, 7: begin
        r = (o == 5) ? (a & b) : (o == 6) ? (a | b) : (a ^ b);
        src = r; szp = 1; nf[0] = 0; nf[4] = 0;
      end
      8:  r = ~a;
      9:  begin r = {a[6:0], a[7]}; nf[0] = a[7]; end
      10: begin r = {a[0], a[7:1]}; nf[0] = a[0]; end
      11: begin r = {a[6:0], f[0]}; nf[0] = a[7]; end
      12: begin r = {f[0], a[7:1]}; nf[0] = a[0]; end
      13: begin
        add = 0;
        if ((a & 15) > 9 || ac) add += 6;
        hi = ((a >> 4) > 9) || cy;
        if (hi) add += 96;
        s = a + add; r = s[7:0]; src = r; szp = 1;
        nf[4] = ((a & 15) + (add & 15)) > 15;
        nf[0] = hi;
      end
      default: r = a;
    endcase
    if (szp) begin
      nf[7] = src[7];
      nf[6] = (src == 8'h00);
      nf[2] = ~^src;
    end
    return {r, nf};
  endfunction

  task automatic apply(input int o, input logic [7:0] a, input logic [7:0] b,
                       input bit we, input string tag);
    logic [15:0] e;
    item_t it;
    @(negedge clk);
    op = 4'(o); acc_in = a; opnd_in = b; flag_we = we;
    e = model(o, a, b, mf);
    it.res = e[15:8];
    it.fl  = we ? e[7:0] : mf;
    it.tag = tag;
    q.push_back(it);
    if (we) mf = e[7:0];
  endtask

  // scoreboard monitor: result before the edge, flags after it
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      #1;
      if (q.size() > 0) begin
        it = q.pop_front();
        checks++;
        if (result !== it.res) begin
          errors++;
          $display("FAIL %s result: got %h expected %h", it.tag, result, it.res);
        end
        @(posedge clk);
        #1;
        checks++;
        if (flags !== it.fl) begin
          errors++;
          $display("FAIL %s flags: got %h expected %h", it.tag, flags, it.fl);
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (flags !== 8'h02) begin  // R1 reset value
      errors++;
      $display("FAIL R1 reset flags: got %h expected 02", flags);
    end
    apply(0,  8'h3A, 8'h2C, 1, "R3 add with nibble carry");
    apply(0,  8'hFF, 8'h01, 1, "R2 R3 add wrap to zero");
    apply(1,  8'h10, 8'h20, 1, "R10 adc uses stored carry");
    apply(1,  8'hF0, 8'h0F, 1, "R3 adc no carry");
    apply(2,  8'h05, 8'h07, 1, "R4 sub borrow");
    apply(3,  8'h50, 8'h10, 1, "R4 sbb with borrow");
    apply(3,  8'h00, 8'h00, 1, "R4 sbb zero");
    apply(4,  8'h40, 8'h40, 1, "R5 compare equal");
    apply(4,  8'h10, 8'h80, 1, "R5 compare below");
    apply(5,  8'hF3, 8'h3C, 1, "R6 and");
    apply(6,  8'h81, 8'h02, 1, "R6 or");
    apply(7,  8'hAA, 8'hAA, 1, "R6 R2 xor zero");
    apply(0,  8'hFF, 8'hFF, 1, "R3 set carry");
    apply(8,  8'h5A, 8'h00, 1, "R7 complement keeps flags");
    apply(9,  8'h81, 8'h00, 1, "R8 rotate left");
    apply(10, 8'h02, 8'h00, 1, "R8 rotate right");
    apply(11, 8'h40, 8'h00, 1, "R8 R10 left through carry");
    apply(12, 8'h01, 8'h00, 1, "R8 R10 right through carry");
    apply(12, 8'h00, 8'h00, 1, "R8 R10 right through carry again");
    apply(0,  8'h38, 8'h45, 1, "R3 bcd add");
    apply(13, 8'h7D, 8'h00, 1, "R9 adjust low nibble");
    apply(0,  8'h55, 8'h55, 1, "R3 bcd add high");
    apply(13, 8'hAA, 8'h00, 1, "R9 adjust both nibbles");
    apply(13, 8'h12, 8'h00, 1, "R9 adjust from stored carry");
    apply(0,  8'hFF, 8'h01, 0, "R10 write disabled");
    apply(1,  8'h00, 8'h00, 1, "R10 adc after disabled write");
    apply(14, 8'h77, 8'h11, 1, "R11 reserved 14");
    apply(15, 8'h00, 8'hFF, 1, "R11 reserved 15");
    apply(2,  8'h10, 8'h01, 1, "R4 sub half borrow");
    @(negedge clk);
    flag_we = 1'b0;
    while (q.size() > 0) @(negedge clk);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule